// File: doc/BRIEF.md
# Sequential Integer Divider with Range Fault

This block divides a double-width dividend by a single-width divisor, one quotient bit per clock. It supports operand widths of 8, 16 and 32 bits, with a selectable signed or unsigned interpretation. The dividend is given as two halves. The upper half supplies the more significant bits. The quotient is returned in one output and the remainder in another.

Two conditions raise a divide fault:
- a divisor of zero;
- a quotient that cannot be represented at the selected operand width.

When a fault is raised, the result outputs keep their earlier contents. The fault flag pulses together with the completion strobe, so the surrounding pipeline can trap instead of writing back.

Signed operands are reduced to magnitudes first. The magnitudes are divided by a restoring shift-subtract loop that runs for twice the operand width. The signs are then reapplied, and the range test runs on the full-length quotient.

Top module: `div_unit`

## Requirements
- R1: `size_sel` picks the operand width W: code 0 selects 8 bits, code 1 selects 16, and codes 2 and 3 select 32. Only bits W-1..0 of `dvd_hi`, `dvd_lo` and `divisor` are used. The dividend is `dvd_hi[W-1:0]` concatenated above `dvd_lo[W-1:0]`.
- R2: On a successful divide, `quo_out` takes the quotient and `rem_out` the remainder, each in bits W-1..0 with the upper bits zero. Both outputs change only in a cycle where `done` is high.
- R3: A divisor whose low W bits are all zero raises `div_fault`. `done` and `div_fault` are then high two cycles after the cycle in which the start was taken.
- R4: In unsigned mode (`signed_mode`=0), a quotient above 2^W-1 raises `div_fault`.
- R5: In signed mode (`signed_mode`=1), operands are two's complement at width 2W (dividend) and W (divisor). The quotient truncates toward zero, and the remainder carries the sign of the dividend.
- R6: In signed mode, a quotient outside -2^(W-1) .. 2^(W-1)-1 raises `div_fault`. -2^(W-1) itself is accepted.
- R7: `div_fault` is high only in a cycle where `done` is high. When it is high, `quo_out` and `rem_out` keep the values they held before.
- R8: With a nonzero divisor, `done` rises 2W+2 cycles after the cycle in which the start was taken, and stays high for exactly one cycle. `busy` is high from the cycle after the start until the cycle before `done`.
- R9: A `start` seen while `busy` is high has no effect on timing, results or fault.
- R10: After reset, `done`, `div_fault` and `busy` are low, and `quo_out` and `rem_out` are zero.
- R11: A `start` in the same cycle as `done` is taken as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a divide when idle |
| signed_mode | input | 1 | 1 = two's complement operands |
| size_sel | input | 2 | Operand width code (0: 8, 1: 16, else 32) |
| dvd_hi | input | 32 | Upper half of the dividend |
| dvd_lo | input | 32 | Lower half of the dividend |
| divisor | input | 32 | Divisor |
| quo_out | output | 32 | Quotient, zero-extended from W bits |
| rem_out | output | 32 | Remainder, zero-extended from W bits |
| done | output | 1 | One-cycle completion strobe |
| div_fault | output | 1 | Divide fault, valid with done |
| busy | output | 1 | Divide in progress |

## Verification
The completion of one divide and the acceptance of the next can fall in the same cycle. The bench provokes this by raising `start` in the very cycle where `done` is seen. It then judges the second operation by counting cycles to its own `done`, and by comparing its quotient and remainder with hand-computed values. A second overlap, a new `start` arriving in mid-iteration, is driven with a zero divisor. If the design wrongly took that start, a fault would appear; the bench checks that none does. A behavioural model compares every port on every clock throughout.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int OPW  = 32;               // widest operand
  localparam int DVW  = 2 * OPW;          // widest dividend
  localparam int CNTW = $clog2(DVW + 1);  // holds iteration counts up to DVW

  // operand width for a size code
  function automatic logic [CNTW-1:0] op_width(input logic [1:0] sz);
    case (sz)
      2'd0:    op_width = CNTW'(8);
      2'd1:    op_width = CNTW'(16);
      default: op_width = CNTW'(OPW);
    endcase
  endfunction

  // ones in the low w bit positions
  function automatic logic [DVW-1:0] low_mask(input logic [CNTW-1:0] w);
    for (int i = 0; i < DVW; i++) low_mask[i] = (i < int'(w));
  endfunction
endpackage

// File: rtl/div_prep.sv
// Masks operands to the selected width, strips signs, left-justifies the dividend.
module div_prep
  import div_pkg::*;
(
  input  logic            sgn,
  input  logic [CNTW-1:0] w,
  input  logic [OPW-1:0]  hi,
  input  logic [OPW-1:0]  lo,
  input  logic [OPW-1:0]  dvs,
  output logic [DVW-1:0]  dvd_just,
  output logic [OPW-1:0]  dvs_mag,
  output logic            q_neg,
  output logic            r_neg,
  output logic            dvs_zero
);
  logic [CNTW-1:0] w2;
  logic [DVW-1:0]  m, m2, full, dmag;
  logic [OPW-1:0]  dv;
  logic            dvd_sign, dvs_sign;

  always_comb begin
    w2       = w << 1;
    m        = low_mask(w);
    m2       = low_mask(w2);
    full     = (({{OPW{1'b0}}, hi} & m) << w) | ({{OPW{1'b0}}, lo} & m);
    dvd_sign = sgn & full[int'(w2) - 1];
    dmag     = dvd_sign ? ((~full + DVW'(1)) & m2) : full;
    dvd_just = dmag << (DVW - int'(w2));
    dv       = dvs & m[OPW-1:0];
    dvs_sign = sgn & dv[int'(w) - 1];
    dvs_mag  = dvs_sign ? ((~dv + OPW'(1)) & m[OPW-1:0]) : dv;
    dvs_zero = (dv == '0);
    q_neg    = dvd_sign ^ dvs_sign;
    r_neg    = dvd_sign;
  end
endmodule

// File: rtl/div_step.sv
// One restoring shift-subtract iteration.
module div_step
  import div_pkg::*;
(
  input  logic [OPW-1:0] part,
  input  logic [DVW-1:0] sh,
  input  logic [OPW-1:0] dvs,
  output logic [OPW-1:0] part_n,
  output logic [DVW-1:0] sh_n
);
  logic [OPW:0]   trial;
  logic [OPW-1:0] diff;
  logic           fits;

  always_comb begin
    trial  = {part, sh[DVW-1]};
    fits   = (trial >= {1'b0, dvs});
    diff   = trial[OPW-1:0] - dvs;
    part_n = fits ? diff : trial[OPW-1:0];
    sh_n   = {sh[DVW-2:0], fits};
  end
endmodule

// File: rtl/div_final.sv
// Restores signs and tests the quotient range for the selected mode.
module div_final
  import div_pkg::*;
(
  input  logic            sgn,
  input  logic [CNTW-1:0] w,
  input  logic            q_neg,
  input  logic            r_neg,
  input  logic [DVW-1:0]  qmag,
  input  logic [OPW-1:0]  rmag,
  output logic [OPW-1:0]  q_out,
  output logic [OPW-1:0]  r_out,
  output logic            range_bad
);
  logic [DVW-1:0] m, half;

  always_comb begin
    m     = low_mask(w);
    half  = {{(DVW-1){1'b0}}, 1'b1} << (int'(w) - 1);
    q_out = (q_neg ? (~qmag[OPW-1:0] + OPW'(1)) : qmag[OPW-1:0]) & m[OPW-1:0];
    r_out = (r_neg ? (~rmag + OPW'(1)) : rmag) & m[OPW-1:0];
    if (!sgn)       range_bad = (qmag > m);
    else if (q_neg) range_bad = (qmag > half);
    else            range_bad = (qmag >= half);
  end
endmodule

// File: rtl/div_unit.sv
module div_unit
  import div_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           signed_mode,
  input  logic [1:0]     size_sel,
  input  logic [OPW-1:0] dvd_hi,
  input  logic [OPW-1:0] dvd_lo,
  input  logic [OPW-1:0] divisor,
  output logic [OPW-1:0] quo_out,
  output logic [OPW-1:0] rem_out,
  output logic           done,
  output logic           div_fault,
  output logic           busy
);
  typedef enum logic {ST_IDLE, ST_RUN} st_t;
  st_t             st_r;
  logic [CNTW-1:0] w_in, w_r, cnt_r;
  logic [DVW-1:0]  sh_r, sh_n, dvd_just;
  logic [OPW-1:0]  part_r, part_n, dvs_r, dvs_mag, q_fin, r_fin;
  logic            sgn_r, qneg_r, rneg_r, dz_r;
  logic            q_neg, r_neg, dvs_zero, range_bad;

  // named events
  logic start_take, iter_fire, fin_fire, fault_fire;

  assign w_in = op_width(size_sel);

  div_prep u_prep (
    .sgn(signed_mode), .w(w_in), .hi(dvd_hi), .lo(dvd_lo), .dvs(divisor),
    .dvd_just(dvd_just), .dvs_mag(dvs_mag), .q_neg(q_neg), .r_neg(r_neg),
    .dvs_zero(dvs_zero)
  );

  div_step u_step (
    .part(part_r), .sh(sh_r), .dvs(dvs_r), .part_n(part_n), .sh_n(sh_n)
  );

  div_final u_final (
    .sgn(sgn_r), .w(w_r), .q_neg(qneg_r), .r_neg(rneg_r), .qmag(sh_r),
    .rmag(part_r), .q_out(q_fin), .r_out(r_fin), .range_bad(range_bad)
  );

  assign busy       = (st_r == ST_RUN);
  assign start_take = start && (st_r == ST_IDLE);
  assign iter_fire  = busy && !dz_r && (cnt_r != '0);
  assign fin_fire   = busy && !dz_r && (cnt_r == '0);
  assign fault_fire = busy && (dz_r || (fin_fire && range_bad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r      <= ST_IDLE;
      w_r       <= '0;
      cnt_r     <= '0;
      sh_r      <= '0;
      part_r    <= '0;
      dvs_r     <= '0;
      sgn_r     <= 1'b0;
      qneg_r    <= 1'b0;
      rneg_r    <= 1'b0;
      dz_r      <= 1'b0;
      quo_out   <= '0;
      rem_out   <= '0;
      done      <= 1'b0;
      div_fault <= 1'b0;
    end else begin
      done      <= 1'b0;
      div_fault <= 1'b0;
      if (start_take) begin
        st_r   <= ST_RUN;
        w_r    <= w_in;
        cnt_r  <= w_in << 1;
        sh_r   <= dvd_just;
        part_r <= '0;
        dvs_r  <= dvs_mag;
        sgn_r  <= signed_mode;
        qneg_r <= q_neg;
        rneg_r <= r_neg;
        dz_r   <= dvs_zero;
      end else if (iter_fire) begin
        part_r <= part_n;
        sh_r   <= sh_n;
        cnt_r  <= cnt_r - CNTW'(1);
      end else if (busy) begin
        st_r      <= ST_IDLE;
        done      <= 1'b1;
        div_fault <= fault_fire;
        if (!fault_fire) begin
          quo_out <= q_fin;
          rem_out <= r_fin;
        end
      end
    end
  end
endmodule

// File: rtl/div_unit_chk.sv
module div_unit_chk
  import div_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           div_fault,
  input logic [OPW-1:0] quo_out,
  input logic [OPW-1:0] rem_out,
  input logic           start_take,
  input logic           dvs_zero
);
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> busy);

  a_r8_no_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  a_r7_fault_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    div_fault |-> done);

  a_r7_hold_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    div_fault |-> ($stable(quo_out) && $stable(rem_out)));

  a_r2_change_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quo_out) && $stable(rem_out)));

  a_r3_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (start_take && dvs_zero) |=> ##1 (done && div_fault));
endmodule

bind div_unit div_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .div_fault(div_fault),
  .quo_out(quo_out), .rem_out(rem_out), .start_take(start_take),
  .dvs_zero(dvs_zero)
);

// File: tb/tb_div_unit.sv
module tb_div_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [1:0]  size_sel = 2'd0;
  logic [31:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
  logic [31:0] quo_out, rem_out;
  logic        done, div_fault, busy;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  div_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .size_sel(size_sel), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
    .quo_out(quo_out), .rem_out(rem_out), .done(done), .div_fault(div_fault),
    .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int w_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
  endfunction

  // behavioural reference from the requirements
  function automatic void ref_div(input logic [1:0] sz, input logic sg,
      input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] dv,
      output logic [31:0] q, output logic [31:0] r, output logic f);
    int w = w_of(sz);
    logic [63:0] m = (64'd1 << w) - 64'd1;
    logic [63:0] d = ((hi & m) << w) | (lo & m);
    logic [63:0] v = dv & m;
    logic [63:0] qu, ru;
    logic signed [127:0] ds, vs, qs, rs, lim;
    q = '0; r = '0; f = 1'b0;
    if (v == 64'd0) begin
      f = 1'b1;
      return;
    end
    if (!sg) begin
      qu = d / v; ru = d % v;
      f = (qu > m);
      q = qu[31:0]; r = ru[31:0];
    end else begin
      ds = $signed({64'd0, d});
      if (d[2*w-1]) ds = ds - (128'sd1 <<< (2*w));
      vs = $signed({64'd0, v});
      if (v[w-1]) vs = vs - (128'sd1 <<< w);
      qs = ds / vs; rs = ds % vs;
      lim = 128'sd1 <<< (w-1);
      f = (qs < -lim) || (qs > lim - 128'sd1);
      q = qs[31:0] & m[31:0]; r = rs[31:0] & m[31:0];
    end
  endfunction

  // cycle model
  logic        m_busy, exp_done, exp_fault, p_f, t_f;
  int          m_cnt;
  logic [31:0] exp_quo, exp_rem, p_q, p_r, t_q, t_r;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_cnt <= 0; exp_done <= 1'b0; exp_fault <= 1'b0;
      exp_quo <= '0; exp_rem <= '0; p_q <= '0; p_r <= '0; p_f <= 1'b0;
    end else begin
      exp_done <= 1'b0; exp_fault <= 1'b0;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_busy <= 1'b0; exp_done <= 1'b1; exp_fault <= p_f;
          if (!p_f) begin exp_quo <= p_q; exp_rem <= p_r; end
        end else m_cnt <= m_cnt - 1;
      end else if (start) begin
        ref_div(size_sel, signed_mode, dvd_hi, dvd_lo, divisor, t_q, t_r, t_f);
        p_q <= t_q; p_r <= t_r; p_f <= t_f; m_busy <= 1'b1;
        m_cnt <= ((divisor & ((64'd1 << w_of(size_sel)) - 64'd1)) == 0) ? 1
                 : 2 * w_of(size_sel) + 1;
      end
    end
  end

  // compare every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 done timing", {31'd0, done}, {31'd0, exp_done});
      chk("R8 busy", {31'd0, busy}, {31'd0, m_busy});
      chk("R7 fault", {31'd0, div_fault}, {31'd0, exp_fault});
      chk("R2 quotient", quo_out, exp_quo);
      chk("R2 remainder", rem_out, exp_rem);
    end
  end

  // drive in the current cycle and wait for done; returns cycles to done
  task automatic issue(input logic [1:0] sz, input logic sg, input logic [31:0] hi,
      input logic [31:0] lo, input logic [31:0] dv, output int lat);
    start = 1'b1; size_sel = sz; signed_mode = sg;
    dvd_hi = hi; dvd_lo = lo; divisor = dv;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 100);
  endtask

  task automatic run_op(input logic [1:0] sz, input logic sg, input logic [31:0] hi,
      input logic [31:0] lo, input logic [31:0] dv, input logic [31:0] eq,
      input logic [31:0] er, input logic ef, input string tag);
    int lat, exp_lat;
    logic [31:0] old_q, old_r;
    @(negedge clk);
    old_q = quo_out; old_r = rem_out;
    exp_lat = ((dv & ((64'd1 << w_of(sz)) - 64'd1)) == 0) ? 2 : 2 * w_of(sz) + 2;
    issue(sz, sg, hi, lo, dv, lat);
    chk({tag, " R8 latency"}, lat, exp_lat);
    chk({tag, " fault"}, {31'd0, div_fault}, {31'd0, ef});
    chk({tag, " quotient"}, quo_out, ef ? old_q : eq);
    chk({tag, " remainder"}, rem_out, ef ? old_r : er);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk("R10 done at reset", {31'd0, done}, 32'd0);
    chk("R10 fault at reset", {31'd0, div_fault}, 32'd0);
    chk("R10 quotient at reset", quo_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy after reset", {31'd0, busy}, 32'd0);
    chk("R10 remainder after reset", rem_out, 32'd0);

    run_op(2'd0, 1'b0, 32'h0, 32'h64, 32'h7, 32'h0E, 32'h02, 1'b0, "R2 byte unsigned");
    run_op(2'd0, 1'b0, 32'hABCDEF00, 32'h12345664, 32'hFFFFFF07, 32'h0E, 32'h02, 1'b0, "R1 upper bits ignored");
    run_op(2'd0, 1'b0, 32'h0F, 32'hF0, 32'h10, 32'hFF, 32'h0, 1'b0, "R4 largest fitting");
    run_op(2'd0, 1'b0, 32'h10, 32'h00, 32'h10, 32'h0, 32'h0, 1'b1, "R4 unsigned overflow");
    run_op(2'd1, 1'b0, 32'h1234, 32'h5678, 32'hFFFF0000, 32'h0, 32'h0, 1'b1, "R3 zero divisor");
    run_op(2'd1, 1'b0, 32'h0001, 32'h0000, 32'h0002, 32'h8000, 32'h0, 1'b0, "R1 word");
    run_op(2'd2, 1'b0, 32'h1, 32'h5, 32'h10, 32'h10000000, 32'h5, 1'b0, "R1 dword");
    run_op(2'd3, 1'b0, 32'h0, 32'h100, 32'h10, 32'h10, 32'h0, 1'b0, "R1 code three");
    run_op(2'd0, 1'b1, 32'hFF, 32'h9C, 32'h07, 32'hF2, 32'hFE, 1'b0, "R5 neg dividend");
    run_op(2'd0, 1'b1, 32'h00, 32'h64, 32'hF9, 32'hF2, 32'h02, 1'b0, "R5 neg divisor");
    run_op(2'd1, 1'b1, 32'h0, 32'h7, 32'hFFFE, 32'hFFFD, 32'h1, 1'b0, "R5 word");
    run_op(2'd1, 1'b1, 32'hFFFF, 32'hFFF9, 32'h2, 32'hFFFD, 32'hFFFF, 1'b0, "R5 truncation");
    run_op(2'd0, 1'b1, 32'hFF, 32'h00, 32'h02, 32'h80, 32'h0, 1'b0, "R6 most negative fits");
    run_op(2'd0, 1'b1, 32'h01, 32'h00, 32'h02, 32'h0, 32'h0, 1'b1, "R6 positive overflow");
    run_op(2'd2, 1'b1, 32'h80000000, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h0, 1'b1, "R6 dword min by minus one");
    run_op(2'd0, 1'b1, 32'h0, 32'h5, 32'h0, 32'h0, 32'h0, 1'b1, "R7 fault holds outputs");

    // R9: start with a zero divisor while busy must be ignored
    @(negedge clk);
    start = 1'b1; size_sel = 2'd2; signed_mode = 1'b0;
    dvd_hi = 32'h0; dvd_lo = 32'h1000; divisor = 32'h10;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    start = 1'b1; divisor = 32'h0; dvd_lo = 32'hDEAD;
    @(negedge clk);
    start = 1'b0;
    chk("R9 still busy", {31'd0, busy}, 32'd1);
    lat = 10;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk("R9 latency unchanged", lat, 66);
    chk("R9 no fault", {31'd0, div_fault}, 32'd0);
    chk("R9 quotient of first op", quo_out, 32'h100);

    // R11: start in the done cycle is taken
    issue(2'd1, 1'b0, 32'h0, 32'h9, 32'h3, lat);
    chk("R11 back-to-back latency", lat, 34);
    chk("R11 quotient", quo_out, 32'h3);
    chk("R11 remainder", rem_out, 32'h0);

    for (int i = 0; i < 24; i++) begin
      logic [1:0] sz;
      sz = 2'($urandom_range(0, 3));
      @(negedge clk);
      issue(sz, 1'($urandom), (i % 3 == 0) ? $urandom : ($urandom & 32'h3F),
            $urandom, (i % 7 == 0) ? 32'h0 : ($urandom | 32'h100), lat);
    end

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule